// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block buffers words between two unrelated clock domains. Words enter on the write clock, are held in a synchronous memory array, and leave on the read clock. Write and read may run at the same time, and no input states which clock is faster. Each domain keeps its own binary pointer plus a Gray-coded copy. The Gray copy crosses into the other domain through a two-stage synchronizer, so the logic is correct for any ratio of clock frequencies.

Two output timings are available. In standard timing a word is driven only after a read request, and the status pins report empty and full. In fall-through timing the oldest word appears on its own, and the same pins report output-ready and input-ready. The timing is captured while master reset is held. Half-full, almost-full and almost-empty flags are also provided. The almost thresholds can be loaded in parallel from the data bus or shifted in serially, and master reset returns them to one of two presets. A partial reset empties the buffer but keeps the thresholds and the timing. A retransmit request rewinds reading to array location zero. The data outputs float while output enable is low.

Top module: `dcfifo_pf`

## Requirements
- R1: While `mrst_n` is low, the timing mode is taken from `mode_sel` (0 standard, 1 fall-through) and both offsets are set to PRESET_A when `preset_sel` is 0 or PRESET_B when it is 1. After any reset the buffer is empty, `rdata` is 0 and `half`/`afull` are low.
- R2: Words leave in the order they were accepted. A write is accepted when `wen` is high, `ld` is low and the write side is not full. A read is performed only when the read side holds a word. Writes when full and reads when empty change nothing.
- R3: In standard timing, `rdata` takes the next word on the read-clock edge that samples `ren` high while the read side is not empty. `empty_or` is high while the read-side count is zero.
- R4: In fall-through timing, a word moves to `rdata` without a read request as soon as the read side holds one. `empty_or` is high while `rdata` carries a valid unread word, and a `ren` consumes it.
- R5: The write-side count is the write pointer minus the read pointer as seen through two write-clock stages. The read-side count is the write pointer as seen through two read-clock stages minus the read pointer. `full_ir` is high at a write-side count of DEPTH in standard timing, and high while below DEPTH in fall-through timing.
- R6: `half` is high when the write-side count exceeds DEPTH/2.
- R7: `afull` is high when the write-side count is at least DEPTH minus the almost-full offset.
- R8: `aempty` is high when the read-side count, which excludes a word already on `rdata`, is at most the almost-empty offset.
- R9: A write-clock edge with `ld` and `wen` both high loads `wdata[AW-1:0]` into the almost-empty offset, then into the almost-full offset on the next such edge, alternating after that. It stores no word.
- R10: A write-clock edge with `sen` high and no parallel load shifts `sdin` into a 2*AW-bit chain, LSB first. The almost-empty offset is filled first, then the almost-full offset.
- R11: A low `prst_n` clears the pointers, the stored words and the parallel-load alternation, and keeps the offsets and the timing mode.
- R12: A read-clock edge with `rt` high sets the read pointer to location 0 and drops any fall-through word. In fall-through timing, location 0 is back on `rdata` one edge later.
- R13: While `oe` is low, every bit of `rdata` is high impedance.
- R14: `mode_sel` and `preset_sel` have no effect while `mrst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low |
| prst_n | input | 1 | Partial reset, active low |
| mode_sel | input | 1 | Timing mode captured during master reset |
| preset_sel | input | 1 | Offset preset choice captured during master reset |
| wdata | input | DW | Write data, also parallel offset value |
| wen | input | 1 | Write enable |
| ld | input | 1 | Parallel offset load strobe (with wen) |
| sen | input | 1 | Serial offset shift enable |
| sdin | input | 1 | Serial offset bit |
| ren | input | 1 | Read enable |
| rt | input | 1 | Retransmit request |
| oe | input | 1 | Output enable for rdata |
| rdata | output | DW | Read data, high impedance when oe is low |
| empty_or | output | 1 | Empty (standard) or output-ready (fall-through) |
| full_ir | output | 1 | Full (standard) or input-ready (fall-through) |
| half | output | 1 | More than half the locations used |
| aempty | output | 1 | Almost empty |
| afull | output | 1 | Almost full |

## Verification
Write and read run on one shared clock, so every delay is a whole number of cycles:
- A word accepted on one edge changes `full_ir`, `half` and `afull` straight away.
- The same word reaches the read-side count, and so `empty_or` in standard timing and `aempty`, two edges later.
- In fall-through timing, `rdata` and `empty_or` follow one edge after that.
- A read moves the write-side flags two edges after it happens.
- Standard-timing data is due on the edge that samples `ren`.
- A fall-through word comes back one edge after a retransmit.

The reference model advances on each rising edge. Outputs are compared one nanosecond after the falling edge, once inputs set on that edge have settled, so each result is checked in the cycle it is due.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  typedef enum logic {TM_STANDARD = 1'b0, TM_FALLTHRU = 1'b1} tmode_e;
endpackage

// File: rtl/dcfifo_gsync.sv
module dcfifo_gsync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d_i;
      hold_q <= meta_q;
    end
  end

  assign q_o = hold_q;
endmodule

// File: rtl/dcfifo_cfg.sv
module dcfifo_cfg import dcfifo_pkg::*; #(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int PRESET_A = 2,
  parameter int PRESET_B = 4
) (
  input  logic          wclk,
  input  logic          mrst_n,
  input  logic          rst_n,
  input  logic          mode_i,
  input  logic          psel_i,
  input  logic          wen_i,
  input  logic          ld_i,
  input  logic          sen_i,
  input  logic          sdin_i,
  input  logic [DW-1:0] wdata_i,
  output tmode_e        mode_o,
  output logic [AW-1:0] ae_off_o,
  output logic [AW-1:0] af_off_o
);
  localparam int OW = 2 * AW;

  function automatic logic [AW-1:0] preset(input logic sel);
    return sel ? AW'(PRESET_B) : AW'(PRESET_A);
  endfunction

  logic [OW-1:0] offs_q;
  logic          sel_q;
  tmode_e        mode_q;
  logic          par_load, ser_load;

  assign par_load = ld_i & wen_i;
  assign ser_load = sen_i & ~par_load;

  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      mode_q <= tmode_e'(mode_i);
      offs_q <= {preset(psel_i), preset(psel_i)};
    end else if (par_load) begin
      if (!sel_q) offs_q[AW-1:0]  <= wdata_i[AW-1:0];
      else        offs_q[OW-1:AW] <= wdata_i[AW-1:0];
    end else if (ser_load) begin
      offs_q <= {sdin_i, offs_q[OW-1:1]};
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n)        sel_q <= 1'b0;
    else if (par_load) sel_q <= ~sel_q;
  end

  assign mode_o   = mode_q;
  assign ae_off_o = offs_q[AW-1:0];
  assign af_off_o = offs_q[OW-1:AW];

  // R9
  offs_hold_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
    (!par_load && !sen_i) |=> $stable(offs_q));

  // R14
  mode_hold_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
    mrst_n |=> $stable(mode_q));
endmodule

// File: rtl/dcfifo_wside.sv
module dcfifo_wside #(
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wen_i,
  input  logic          ld_i,
  input  logic [AW:0]   rgray_s_i,
  input  logic [AW-1:0] af_off_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          full_o,
  output logic          half_o,
  output logic          afull_o
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1 << AW);
  localparam logic [PW-1:0] HALF  = DEPTH >> 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [PW-1:0] wbin_q, wgray_q, rbin_s, wcount, wnext;

  assign rbin_s  = g2b(rgray_s_i);
  assign wcount  = wbin_q - rbin_s;
  assign full_o  = (wcount == DEPTH);
  assign half_o  = (wcount > HALF);
  assign afull_o = (wcount >= (DEPTH - {1'b0, af_off_i}));
  assign we_o    = rst_n & wen_i & ~ld_i & ~full_o;
  assign wnext   = wbin_q + PW'(1);

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (we_o) begin
      wbin_q  <= wnext;
      wgray_q <= b2g(wnext);
    end
  end

  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wgray_q;

  // R2
  wfull_stall_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    full_o |=> $stable(wbin_q));

  // R2
  wptr_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    1'b1 |=> ((wbin_q - $past(wbin_q)) <= PW'(1)));

  // R5
  wgray_onebit_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    1'b1 |=> ($countones(wgray_q ^ $past(wgray_q)) <= 1));
endmodule

// File: rtl/dcfifo_rside.sv
module dcfifo_rside import dcfifo_pkg::*; #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  tmode_e        mode_i,
  input  logic          ren_i,
  input  logic          rt_i,
  input  logic [AW:0]   wgray_s_i,
  input  logic [AW-1:0] ae_off_i,
  input  logic [DW-1:0] mem_q_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] dout_o,
  output logic          empty_or_o,
  output logic          aempty_o
);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [PW-1:0] rbin_q, rgray_q, wbin_s, rcount, rnext;
  logic [DW-1:0] dout_q;
  logic          vld_q, empty_int, fwft, take;

  assign fwft      = (mode_i == TM_FALLTHRU);
  assign wbin_s    = g2b(wgray_s_i);
  assign rcount    = wbin_s - rbin_q;
  assign empty_int = (rcount == '0);
  assign rnext     = rbin_q + PW'(1);
  assign take      = fwft ? (!empty_int && (!vld_q || ren_i))
                          : (ren_i && !empty_int);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      vld_q   <= 1'b0;
      dout_q  <= '0;
    end else if (rt_i) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      vld_q   <= 1'b0;
    end else if (take) begin
      dout_q  <= mem_q_i;
      rbin_q  <= rnext;
      rgray_q <= b2g(rnext);
      vld_q   <= 1'b1;
    end else if (ren_i) begin
      vld_q   <= 1'b0;
    end
  end

  assign raddr_o    = rbin_q[AW-1:0];
  assign rgray_o    = rgray_q;
  assign dout_o     = dout_q;
  assign empty_or_o = fwft ? vld_q : empty_int;
  assign aempty_o   = (rcount <= {1'b0, ae_off_i});

  // R2
  rempty_idle_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (empty_int && !rt_i) |=> $stable(rbin_q));

  // R4
  fwft_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft && vld_q && !ren_i && !rt_i) |=> (vld_q && $stable(dout_q)));

  // R12
  rt_rewind_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rt_i |=> (rbin_q == '0));
endmodule

// File: rtl/dcfifo_pf.sv
module dcfifo_pf import dcfifo_pkg::*; #(
  parameter int DW       = 8,
  parameter int AW       = 4,
  parameter int PRESET_A = 2,
  parameter int PRESET_B = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          mode_sel,
  input  logic          preset_sel,
  input  logic [DW-1:0] wdata,
  input  logic          wen,
  input  logic          ld,
  input  logic          sen,
  input  logic          sdin,
  input  logic          ren,
  input  logic          rt,
  input  logic          oe,
  output logic [DW-1:0] rdata,
  output logic          empty_or,
  output logic          full_ir,
  output logic          half,
  output logic          aempty,
  output logic          afull
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic          rst_n;
  tmode_e        mode;
  logic [AW-1:0] ae_off, af_off, waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic          we, full_int;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] dout;

  assign rst_n = mrst_n & prst_n;

  dcfifo_cfg #(.AW(AW), .DW(DW), .PRESET_A(PRESET_A), .PRESET_B(PRESET_B)) u_cfg (
    .wclk(wclk), .mrst_n(mrst_n), .rst_n(rst_n), .mode_i(mode_sel), .psel_i(preset_sel),
    .wen_i(wen), .ld_i(ld), .sen_i(sen), .sdin_i(sdin), .wdata_i(wdata),
    .mode_o(mode), .ae_off_o(ae_off), .af_off_o(af_off));

  dcfifo_gsync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d_i(rgray), .q_o(rgray_s));
  dcfifo_gsync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d_i(wgray), .q_o(wgray_s));

  dcfifo_wside #(.AW(AW)) u_wside (
    .wclk(wclk), .rst_n(rst_n), .wen_i(wen), .ld_i(ld), .rgray_s_i(rgray_s),
    .af_off_i(af_off), .we_o(we), .waddr_o(waddr), .wgray_o(wgray),
    .full_o(full_int), .half_o(half), .afull_o(afull));

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  dcfifo_rside #(.AW(AW), .DW(DW)) u_rside (
    .rclk(rclk), .rst_n(rst_n), .mode_i(mode), .ren_i(ren), .rt_i(rt),
    .wgray_s_i(wgray_s), .ae_off_i(ae_off), .mem_q_i(mem[raddr]),
    .raddr_o(raddr), .rgray_o(rgray), .dout_o(dout),
    .empty_or_o(empty_or), .aempty_o(aempty));

  assign full_ir = (mode == TM_FALLTHRU) ? ~full_int : full_int;
  assign rdata   = oe ? dout : 'z;
endmodule

// File: tb/tb_dcfifo_pf.sv
`timescale 1ns/1ps
module tb_dcfifo_pf;
  localparam int DW = 8, AW = 4, PA = 2, PB = 4;
  localparam int D = 1 << AW, M = 2 * D;

  logic clk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1, mode_sel = 1'b0, preset_sel = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic wen = 0, ld = 0, sen = 0, sdin = 0, ren = 0, rt = 0, oe = 1;
  logic [DW-1:0] rdata;
  logic empty_or, full_ir, half, aempty, afull;

  dcfifo_pf #(.DW(DW), .AW(AW), .PRESET_A(PA), .PRESET_B(PB)) dut (
    .wclk(clk), .rclk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_sel(mode_sel),
    .preset_sel(preset_sel), .wdata(wdata), .wen(wen), .ld(ld), .sen(sen), .sdin(sdin),
    .ren(ren), .rt(rt), .oe(oe), .rdata(rdata), .empty_or(empty_or), .full_ir(full_ir),
    .half(half), .aempty(aempty), .afull(afull));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string ctx = "R1";

  // behavioural reference state
  int mem_m [D];
  int wp = 0, rp = 0, ws1 = 0, ws2 = 0, rs1 = 0, rs2 = 0;
  int q = 0, ae = PA, af = PA, lsel = 0;
  bit vld = 0, fw = 0;

  always @(posedge clk) begin
    int nwp, nrp, wc, rc, comb;
    if (!mrst_n) begin
      fw = mode_sel;
      ae = preset_sel ? PB : PA;
      af = ae;
    end else if (ld && wen) begin
      if (lsel == 0) ae = wdata % D; else af = wdata % D;
    end else if (sen) begin
      comb = (af << AW) | ae;
      comb = (comb >> 1) | (int'(sdin) << (2 * AW - 1));
      ae = comb % D;
      af = comb >> AW;
    end
    if (!(mrst_n && prst_n)) begin
      wp = 0; rp = 0; ws1 = 0; ws2 = 0; rs1 = 0; rs2 = 0;
      vld = 0; q = 0; lsel = 0;
    end else begin
      if (ld && wen) lsel ^= 1;
      wc = (wp - rs2 + M) % M;
      rc = (ws2 - rp + M) % M;
      nwp = wp; nrp = rp;
      if (rt) begin
        nrp = 0; vld = 0;
      end else if (!fw) begin
        if (ren && rc != 0) begin q = mem_m[rp % D]; nrp = (rp + 1) % M; vld = 1; end
      end else begin
        if (rc != 0 && (!vld || ren)) begin q = mem_m[rp % D]; nrp = (rp + 1) % M; vld = 1; end
        else if (ren) vld = 0;
      end
      if (wen && !ld && wc != D) begin mem_m[wp % D] = wdata; nwp = (wp + 1) % M; end
      rs2 = rs1; rs1 = rp;
      ws2 = ws1; ws1 = wp;
      wp = nwp; rp = nrp;
    end
  end

  task automatic chk_bit(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s/%s %s actual=%b expected=%b at %0t", ctx, tag, nm, act, exp, $time);
    end
  endtask

  task automatic chk_bus(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s/%s rdata actual=%h expected=%h at %0t", ctx, tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int wc, rc;
    logic [DW-1:0] ed;
    if (!(mrst_n && prst_n)) return;
    wc = (wp - rs2 + M) % M;
    rc = (ws2 - rp + M) % M;
    ed = oe ? DW'(q) : 'z;
    chk_bus(oe ? (fw ? "R4" : "R3") : "R13", rdata, ed);
    chk_bit(fw ? "R4" : "R3", "empty_or", empty_or, fw ? vld : (rc == 0));
    chk_bit("R5", "full_ir", full_ir, fw ? (wc != D) : (wc == D));
    chk_bit("R6", "half", half, wc > D / 2);
    chk_bit("R7", "afull", afull, wc >= D - af);
    chk_bit("R8", "aempty", aempty, rc <= ae);
  endtask

  task automatic tick();
    @(negedge clk); #1;
    compare();
  endtask

  task automatic idle();
    wen = 0; ld = 0; sen = 0; ren = 0; rt = 0;
  endtask

  task automatic master_reset(bit m, bit p);
    idle(); mrst_n = 0; mode_sel = m; preset_sel = p;
    repeat (3) tick();
    mrst_n = 1;
    tick();
  endtask

  task automatic rand_run(int n, int pw, int pr);
    for (int i = 0; i < n; i++) begin
      wen = ($urandom % 100) < pw;
      ren = ($urandom % 100) < pr;
      wdata = DW'($urandom);
      tick();
    end
    idle();
  endtask

  initial begin
    // R1: reset state, standard timing, preset A
    master_reset(0, 0);
    ctx = "R1";
    chk_bit("R1", "empty_or", empty_or, 1'b1);
    chk_bit("R1", "full_ir", full_ir, 1'b0);
    chk_bit("R1", "half", half, 1'b0);
    chk_bit("R1", "afull", afull, 1'b0);
    chk_bit("R1", "aempty", aempty, 1'b1);
    chk_bus("R1", rdata, '0);
    // R14: pins flipped after reset have no effect
    ctx = "R14"; mode_sel = 1; preset_sel = 1;
    rand_run(40, 60, 20);
    // R2: overflow then underflow attempts
    ctx = "R2"; wen = 1;
    for (int i = 0; i < D + 6; i++) begin wdata = DW'(i + 8'h40); tick(); end
    idle(); repeat (3) tick();
    ren = 1; repeat (D + 8) tick(); idle(); tick();
    rand_run(300, 55, 45);
    rand_run(150, 80, 30);
    rand_run(150, 30, 80);
    // R9: parallel load almost-empty 5, almost-full 3
    ctx = "R9"; wen = 1; ld = 1;
    wdata = 8'd5; tick();
    wdata = 8'd3; tick();
    idle(); rand_run(200, 60, 40);
    // R10: serial load almost-empty 1, almost-full 6
    ctx = "R10";
    for (int i = 0; i < 2 * AW; i++) begin
      sen = 1; sdin = ((((6 << AW) | 1) >> i) & 1) != 0; tick();
    end
    idle(); rand_run(200, 60, 40);
    // R11: partial reset keeps offsets and mode
    ctx = "R11"; wen = 1; repeat (7) begin wdata = DW'($urandom); tick(); end
    idle(); prst_n = 0; repeat (2) tick(); prst_n = 1; tick();
    rand_run(150, 60, 40);
    // R12: retransmit in standard timing
    ctx = "R12"; prst_n = 0; repeat (2) tick(); prst_n = 1; tick();
    wen = 1; for (int i = 0; i < 6; i++) begin wdata = DW'(8'hA0 + i); tick(); end
    idle(); repeat (3) tick();
    ren = 1; repeat (3) tick(); idle();
    rt = 1; tick(); rt = 0;
    ren = 1; repeat (8) tick(); idle(); tick();
    // R4: fall-through timing, preset B
    master_reset(1, 1);
    ctx = "R4";
    rand_run(300, 55, 45);
    wen = 1; repeat (D + 3) begin wdata = DW'($urandom); tick(); end
    idle(); rand_run(200, 30, 70);
    // R12: retransmit in fall-through timing
    ctx = "R12"; prst_n = 0; repeat (2) tick(); prst_n = 1; tick();
    wen = 1; for (int i = 0; i < 5; i++) begin wdata = DW'(8'hC0 + i); tick(); end
    idle(); repeat (4) tick();
    ren = 1; repeat (2) tick(); idle();
    rt = 1; tick(); rt = 0; repeat (3) tick();
    ren = 1; repeat (7) tick(); idle(); tick();
    // R13: output enable low floats rdata
    ctx = "R13";
    for (int i = 0; i < 60; i++) begin
      oe = (i % 4) != 0;
      wen = ($urandom % 2) == 1; ren = ($urandom % 3) == 0; wdata = DW'($urandom);
      tick();
    end
    idle(); oe = 1; tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule